// File: doc/BRIEF.md
# Calendar Time Counter with Format Conversion

This block holds a time of day and a calendar date: seconds, minutes, hours, a day-of-week count, day of month, month and a two-digit year. A one-cycle increment strobe advances the whole set by one second and carries through every field, including month lengths and leap years. The state is always kept in plain binary. It is converted on the way out, and converted back on the way in, according to two format controls. One control selects packed decimal (tens digit in bits 7:4, units digit in bits 3:0) or plain binary. The other selects 24-hour or 12-hour hours.

A host loads a new time by presenting all seven field bytes with a load strobe. The bytes are read in whatever format the controls select at that moment. The seven outputs are combinational views of the binary state. Changing a format control therefore changes how the outputs look at once, and leaves the stored time as it was. Loaded values are assumed to be legal for the selected format.

Top module: `tod_calendar`

## Requirements
- R1: A synchronous active-low reset sets the time to 00:00:00, the day-of-week count to 0, the day of month to 1, the month to 1 and the year to 0.
- R2: With `fmt_bin_i` low, every output byte is packed decimal: tens digit in bits 7:4 and units digit in bits 3:0.
- R3: With `fmt_bin_i` high, every output byte is the plain binary value of its field.
- R4: With `fmt_24h_i` high, `hr_o` shows 0 to 23 and bit 7 is clear. With it low, `hr_o` bits 6:0 show the hour modulo 12 in the selected number format, and bit 7 is set for hours 12 to 23.
- R5: On an increment, seconds advance and wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry into the date.
- R6: The day of month wraps to 1 after the last day of its month: 30 for months 4, 6, 9 and 11; 31 for the other long months; 29 for month 2 when the year is divisible by 4, and 28 for month 2 in other years.
- R7: The day-of-week count advances by one on each day carry and wraps from 6 to 0.
- R8: The month wraps from 12 to 1 with a carry into the year, and the year wraps from 99 to 0.
- R9: A load stores all seven input bytes, decoded from the format selected in that cycle. In 12-hour form, input bit 7 marks a PM hour and adds 12. When a load and an increment arrive in the same cycle, the load wins.
- R10: With neither strobe asserted, the stored time does not change, even when the format controls change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Advance the time by one second |
| load_i | input | 1 | Store the seven `ld_*` bytes |
| fmt_bin_i | input | 1 | 1 = plain binary, 0 = packed decimal |
| fmt_24h_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag in bit 7 |
| ld_sec_i | input | 8 | Seconds to load |
| ld_min_i | input | 8 | Minutes to load |
| ld_hr_i | input | 8 | Hours to load |
| ld_dow_i | input | 8 | Day-of-week count to load |
| ld_dom_i | input | 8 | Day of month to load |
| ld_mon_i | input | 8 | Month to load |
| ld_yr_i | input | 8 | Year to load |
| sec_o | output | 8 | Seconds, formatted |
| min_o | output | 8 | Minutes, formatted |
| hr_o | output | 8 | Hours, formatted |
| dow_o | output | 8 | Day-of-week count, formatted |
| dom_o | output | 8 | Day of month, formatted |
| mon_o | output | 8 | Month, formatted |
| yr_o | output | 8 | Year, formatted |

## Verification
The outputs are combinational views of the stored state, so a wrong carry, a wrong month length or a bad decode on load appears at the ports one clock after the strobe that caused it. The bench's model compares all seven fields on every clock. A fault in the month-length or year carry stays hidden until the counter reaches that boundary. Because of this, directed loads put the state one second before each month end, before a leap and a non-leap February, and before the end of the year. A format fault, by contrast, shows in the same cycle that the control changes.

// File: rtl/tod_pkg.sv
// Package: shared field layout, state type and number-format helpers for
// the calendar counter. Assumes all field values fit in 7 bits (0..99).
package tod_pkg;

    localparam int REG_W      = 8;
    localparam int VAL_W      = 7;
    localparam int NUM_FIELDS = 7;

    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DOW = 3;
    localparam int F_DOM = 4;
    localparam int F_MON = 5;
    localparam int F_YR  = 6;

    // Binary time state, one field per calendar unit.
    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

    typedef logic [NUM_FIELDS-1:0][REG_W-1:0] tod_regs_t;
    typedef logic [NUM_FIELDS-1:0][VAL_W-1:0] tod_vals_t;

    // Binary 0..99 to packed decimal.
    function automatic logic [REG_W-1:0] to_bcd(input logic [VAL_W-1:0] v);
        logic [3:0] tens;
        logic [3:0] units;
        tens  = 4'(v / 7'd10);
        units = 4'(v % 7'd10);
        return {tens, units};
    endfunction

    // Packed decimal to binary 0..99.
    function automatic logic [VAL_W-1:0] from_bcd(input logic [REG_W-1:0] b);
        return (7'(b[7:4]) * 7'd10) + 7'(b[3:0]);
    endfunction

    // Number of days in a month; every fourth year has a long February.
    function automatic logic [4:0] days_in_month(input logic [3:0] mon,
                                                 input logic [6:0] yr);
        logic [4:0] len;
        case (mon)
            4'd2:                      len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
            default:                   len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/tod_counter.sv
// Module: tod_counter
// Holds the binary time state and advances it one second per tick, with
// the full carry chain through the date. A load replaces the whole state
// and takes priority over a tick. Assumes loaded values are in range.
module tod_counter
    import tod_pkg::*;
#(
    parameter int DOW_LAST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_i,
    input  tod_t load_val_i,
    output tod_t now_o
);

    localparam logic [2:0] DOW_TOP = 3'(DOW_LAST);
    localparam tod_t RESET_VAL = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd0,
                                   hr: 5'd0, min: 6'd0, sec: 6'd0};

    tod_t       cur_q;
    tod_t       nxt;
    logic [4:0] month_len;
    logic       sec_wrap;
    logic       min_wrap;
    logic       hr_wrap;
    logic       day_wrap;
    logic       mon_wrap;

    // Carry terms: each unit wraps only when all lower units wrap.
    always_comb begin
        month_len = days_in_month(cur_q.mon, cur_q.yr);
        sec_wrap  = (cur_q.sec == 6'd59);
        min_wrap  = sec_wrap && (cur_q.min == 6'd59);
        hr_wrap   = min_wrap && (cur_q.hr == 5'd23);
        day_wrap  = hr_wrap && (cur_q.dom == month_len);
        mon_wrap  = day_wrap && (cur_q.mon == 4'd12);
    end

    // Next state for a one-second advance.
    always_comb begin
        nxt     = cur_q;
        nxt.sec = sec_wrap ? 6'd0 : cur_q.sec + 6'd1;
        if (sec_wrap) begin
            nxt.min = (cur_q.min == 6'd59) ? 6'd0 : cur_q.min + 6'd1;
        end
        if (min_wrap) begin
            nxt.hr = (cur_q.hr == 5'd23) ? 5'd0 : cur_q.hr + 5'd1;
        end
        if (hr_wrap) begin
            nxt.dow = (cur_q.dow == DOW_TOP) ? 3'd0 : cur_q.dow + 3'd1;
            nxt.dom = day_wrap ? 5'd1 : cur_q.dom + 5'd1;
        end
        if (day_wrap) begin
            nxt.mon = (cur_q.mon == 4'd12) ? 4'd1 : cur_q.mon + 4'd1;
        end
        if (mon_wrap) begin
            nxt.yr = (cur_q.yr == 7'd99) ? 7'd0 : cur_q.yr + 7'd1;
        end
    end

    // State register: reset, then load over tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= RESET_VAL;
        end else if (load_i) begin
            cur_q <= load_val_i;
        end else if (tick_i) begin
            cur_q <= nxt;
        end
    end

    assign now_o = cur_q;

    // Time-of-day fields stay in range.
    p_tod_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.sec < 6'd60) && (cur_q.min < 6'd60) && (cur_q.hr < 5'd24));

    // A seconds wrap carries into minutes (R5).
    p_min_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cur_q.sec == 6'd59 && cur_q.min != 6'd59)
        |=> (cur_q.sec == 6'd0) && (cur_q.min == $past(cur_q.min) + 6'd1));

    // Day of month stays within its month.
    p_dom_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.dom >= 5'd1) && (cur_q.dom <= days_in_month(cur_q.mon, cur_q.yr)));

    // Day-of-week count steps on midnight.
    p_dow_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cur_q.sec == 6'd59 && cur_q.min == 6'd59 && cur_q.hr == 5'd23)
        |=> cur_q.dow == (($past(cur_q.dow) == DOW_TOP) ? 3'd0 : $past(cur_q.dow) + 3'd1));

    // End of year 99 wraps to 1 January of year 0.
    p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cur_q.yr == 7'd99 && cur_q.mon == 4'd12 && cur_q.dom == 5'd31
         && cur_q.hr == 5'd23 && cur_q.min == 6'd59 && cur_q.sec == 6'd59)
        |=> (cur_q.yr == 7'd0) && (cur_q.mon == 4'd1) && (cur_q.dom == 5'd1));

    // Month stays 1..12.
    p_mon_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mon >= 4'd1) && (cur_q.mon <= 4'd12));

    // No strobe, no change.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cur_q));

endmodule

// File: rtl/tod_encode.sv
// Module: tod_encode
// Presents the binary state as seven bytes, in packed decimal or binary,
// with hours folded to 12-hour form plus a PM flag when selected.
// Purely combinational; assumes the state is in range.
module tod_encode
    import tod_pkg::*;
(
    input  tod_t      now_i,
    input  logic      fmt_bin_i,
    input  logic      fmt_24h_i,
    output tod_regs_t regs_o
);

    tod_vals_t  plain;
    logic       pm;
    logic [4:0] hr_fold;

    // Hour folding for 12-hour display.
    always_comb begin
        pm      = (now_i.hr >= 5'd12);
        hr_fold = pm ? (now_i.hr - 5'd12) : now_i.hr;
    end

    // Widen every field to a common value width.
    always_comb begin
        plain        = '0;
        plain[F_SEC] = 7'(now_i.sec);
        plain[F_MIN] = 7'(now_i.min);
        plain[F_HR]  = fmt_24h_i ? 7'(now_i.hr) : 7'(hr_fold);
        plain[F_DOW] = 7'(now_i.dow);
        plain[F_DOM] = 7'(now_i.dom);
        plain[F_MON] = 7'(now_i.mon);
        plain[F_YR]  = now_i.yr;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [REG_W-1:0] coded;
        // Number-format selection per field.
        assign coded = fmt_bin_i ? {1'b0, plain[g]} : to_bcd(plain[g]);
        if (g == F_HR) begin : g_hour
            // PM flag replaces bit 7 in 12-hour form.
            assign regs_o[g] = fmt_24h_i ? coded : {pm, coded[6:0]};
        end else begin : g_plain
            assign regs_o[g] = coded;
        end
    end

endmodule

// File: rtl/tod_decode.sv
// Module: tod_decode
// Converts seven host bytes in the selected format back into the binary
// state. In 12-hour form bit 7 of the hour byte marks PM and adds 12.
// Purely combinational; assumes legal input values.
module tod_decode
    import tod_pkg::*;
(
    input  tod_regs_t regs_i,
    input  logic      fmt_bin_i,
    input  logic      fmt_24h_i,
    output tod_t      val_o
);

    tod_vals_t  plain;
    logic       pm;
    logic [4:0] hr_full;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [REG_W-1:0] src;
        if (g == F_HR) begin : g_hour
            // Strip the PM flag before number decoding.
            assign src = fmt_24h_i ? regs_i[g] : {1'b0, regs_i[g][6:0]};
        end else begin : g_plain
            assign src = regs_i[g];
        end
        // Number-format selection per field.
        assign plain[g] = fmt_bin_i ? src[6:0] : from_bcd(src);
    end

    // Unfold 12-hour form.
    always_comb begin
        pm      = !fmt_24h_i && regs_i[F_HR][7];
        hr_full = 5'(plain[F_HR]) + (pm ? 5'd12 : 5'd0);
    end

    // Narrow values into the state fields.
    always_comb begin
        val_o.sec = 6'(plain[F_SEC]);
        val_o.min = 6'(plain[F_MIN]);
        val_o.hr  = hr_full;
        val_o.dow = 3'(plain[F_DOW]);
        val_o.dom = 5'(plain[F_DOM]);
        val_o.mon = 4'(plain[F_MON]);
        val_o.yr  = plain[F_YR];
    end

endmodule

// File: rtl/tod_calendar.sv
// Module: tod_calendar (top)
// Calendar time counter with format conversion on both load and read.
// The state is binary; formats apply only at the edges.
// Assumes loaded bytes are legal in the format selected at the load.
module tod_calendar
    import tod_pkg::*;
#(
    parameter int DOW_LAST = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic       fmt_bin_i,
    input  logic       fmt_24h_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hr_i,
    input  logic [7:0] ld_dow_i,
    input  logic [7:0] ld_dom_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_yr_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic [7:0] dow_o,
    output logic [7:0] dom_o,
    output logic [7:0] mon_o,
    output logic [7:0] yr_o
);

    tod_regs_t ld_regs;
    tod_regs_t out_regs;
    tod_t      ld_val;
    tod_t      now;

    // Gather host bytes into field order.
    always_comb begin
        ld_regs        = '0;
        ld_regs[F_SEC] = ld_sec_i;
        ld_regs[F_MIN] = ld_min_i;
        ld_regs[F_HR]  = ld_hr_i;
        ld_regs[F_DOW] = ld_dow_i;
        ld_regs[F_DOM] = ld_dom_i;
        ld_regs[F_MON] = ld_mon_i;
        ld_regs[F_YR]  = ld_yr_i;
    end

    tod_decode i_decode (
        .regs_i    (ld_regs),
        .fmt_bin_i (fmt_bin_i),
        .fmt_24h_i (fmt_24h_i),
        .val_o     (ld_val)
    );

    tod_counter #(.DOW_LAST(DOW_LAST)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (load_i),
        .load_val_i (ld_val),
        .now_o      (now)
    );

    tod_encode i_encode (
        .now_i     (now),
        .fmt_bin_i (fmt_bin_i),
        .fmt_24h_i (fmt_24h_i),
        .regs_o    (out_regs)
    );

    assign sec_o = out_regs[F_SEC];
    assign min_o = out_regs[F_MIN];
    assign hr_o  = out_regs[F_HR];
    assign dow_o = out_regs[F_DOW];
    assign dom_o = out_regs[F_DOM];
    assign mon_o = out_regs[F_MON];
    assign yr_o  = out_regs[F_YR];

    // Packed-decimal units digits stay below ten.
    p_bcd_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_bin_i |-> (sec_o[3:0] <= 4'd9) && (min_o[3:0] <= 4'd9) && (yr_o[3:0] <= 4'd9));

    // Binary form shows the stored value.
    p_bin_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_bin_i |-> (sec_o == {2'b00, now.sec}) && (yr_o == {1'b0, now.yr}));

    // PM flag follows the stored hour in 12-hour form.
    p_pm_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_24h_i |-> (hr_o[7] == (now.hr >= 5'd12)));

    // No flag in 24-hour form.
    p_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_24h_i |-> !hr_o[7]);

    // A load stores the decoded bytes, over any tick.
    p_load_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (now == $past(ld_val)));

endmodule

// File: tb/test_tod_calendar.sv
// Bench for tod_calendar: behavioural integer model updated every clock,
// full output comparison every clock, plus directed boundary checks.
module test_tod_calendar;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic       fbin = 1'b0;
    logic       f24 = 1'b1;
    logic [7:0] l_sec = '0, l_min = '0, l_hr = '0, l_dow = '0, l_dom = '0, l_mon = '0, l_yr = '0;
    logic [7:0] sec_o, min_o, hr_o, dow_o, dom_o, mon_o, yr_o;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    int ms, mm, mh, mw, md, mmo, my;

    always #2 clk = ~clk;

    tod_calendar i_tod_calendar (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
        .fmt_bin_i(fbin), .fmt_24h_i(f24),
        .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hr_i(l_hr), .ld_dow_i(l_dow),
        .ld_dom_i(l_dom), .ld_mon_i(l_mon), .ld_yr_i(l_yr),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .dow_o(dow_o),
        .dom_o(dom_o), .mon_o(mon_o), .yr_o(yr_o)
    );

    function automatic int enc(int v, bit b);
        return b ? v : (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int enc_hr(int h, bit b, bit h24);
        if (h24) return enc(h, b);
        return enc(h % 12, b) + ((h >= 12) ? 128 : 0);
    endfunction

    function automatic int dec(int x, bit b);
        return b ? x : (x / 16) * 10 + (x % 16);
    endfunction

    function automatic int dec_hr(int x, bit b, bit h24);
        if (h24) return dec(x, b);
        return dec(x % 128, b) + ((x >= 128) ? 12 : 0);
    endfunction

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got 0x%02h expected 0x%02h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task advance();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mw = (mw + 1) % 7;
                    md++;
                    if (md > mlen(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1;
                            my = (my + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    // Reference model: same edge as the design, behavioural arithmetic.
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mmo = 1; my = 0;
        end else if (load) begin
            ms = dec(l_sec, fbin); mm = dec(l_min, fbin);
            mh = dec_hr(l_hr, fbin, f24); mw = dec(l_dow, fbin);
            md = dec(l_dom, fbin); mmo = dec(l_mon, fbin); my = dec(l_yr, fbin);
        end else if (tick) begin
            advance();
        end
    end

    // Per-clock comparison of all outputs against the model.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(fbin ? "R3" : "R2", "sec", sec_o, enc(ms, fbin));
            chk(fbin ? "R3" : "R2", "min", min_o, enc(mm, fbin));
            chk(f24 ? (fbin ? "R3" : "R2") : "R4", "hour", hr_o, enc_hr(mh, fbin, f24));
            chk(fbin ? "R3" : "R2", "dow", dow_o, enc(mw, fbin));
            chk(fbin ? "R3" : "R2", "dom", dom_o, enc(md, fbin));
            chk(fbin ? "R3" : "R2", "mon", mon_o, enc(mmo, fbin));
            chk(fbin ? "R3" : "R2", "yr", yr_o, enc(my, fbin));
        end
    end

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic set_fmt(bit b, bit h);
        @(negedge clk); fbin = b; f24 = h;
    endtask

    task automatic strobe(bit ld, bit tk);
        @(negedge clk); load = ld; tick = tk;
        settle();
        load = 1'b0; tick = 1'b0;
    endtask

    task automatic load_raw(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w,
                            logic [7:0] d, logic [7:0] mo, logic [7:0] y, bit tk);
        @(negedge clk);
        l_sec = s; l_min = m; l_hr = h; l_dow = w; l_dom = d; l_mon = mo; l_yr = y;
        load = 1'b1; tick = tk;
        settle();
        load = 1'b0; tick = 1'b0;
    endtask

    task automatic load_time(int h, int m, int s, int w, int d, int mo, int y);
        load_raw(8'(enc(s, fbin)), 8'(enc(m, fbin)), 8'(enc_hr(h, fbin, f24)),
                 8'(enc(w, fbin)), 8'(enc(d, fbin)), 8'(enc(mo, fbin)), 8'(enc(y, fbin)), 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) settle();
        // R1: reset state in packed decimal, 24-hour.
        chk("R1", "sec", sec_o, 8'h00);
        chk("R1", "hour", hr_o, 8'h00);
        chk("R1", "dow", dow_o, 8'h00);
        chk("R1", "dom", dom_o, 8'h01);
        chk("R1", "mon", mon_o, 8'h01);
        chk("R1", "yr", yr_o, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R5: carries from seconds through hours.
        load_time(0, 59, 58, 2, 15, 6, 21);
        strobe(1'b0, 1'b1);
        chk("R5", "sec", sec_o, 8'h59);
        strobe(1'b0, 1'b1);
        chk("R5", "sec", sec_o, 8'h00);
        chk("R5", "min", min_o, 8'h00);
        chk("R5", "hour", hr_o, 8'h01);

        // R8 and R7: year end.
        load_time(23, 59, 59, 6, 31, 12, 99);
        strobe(1'b0, 1'b1);
        chk("R8", "yr", yr_o, 8'h00);
        chk("R8", "mon", mon_o, 8'h01);
        chk("R8", "dom", dom_o, 8'h01);
        chk("R7", "dow", dow_o, 8'h00);

        // R6: month lengths and leap rule.
        load_time(23, 59, 59, 1, 28, 2, 4);
        strobe(1'b0, 1'b1);
        chk("R6", "leap dom", dom_o, 8'h29);
        chk("R6", "leap mon", mon_o, 8'h02);
        load_time(23, 59, 59, 1, 29, 2, 4);
        strobe(1'b0, 1'b1);
        chk("R6", "leap end dom", dom_o, 8'h01);
        chk("R6", "leap end mon", mon_o, 8'h03);
        load_time(23, 59, 59, 1, 28, 2, 3);
        strobe(1'b0, 1'b1);
        chk("R6", "plain feb dom", dom_o, 8'h01);
        chk("R6", "plain feb mon", mon_o, 8'h03);
        load_time(23, 59, 59, 1, 30, 4, 21);
        strobe(1'b0, 1'b1);
        chk("R6", "apr dom", dom_o, 8'h01);
        chk("R6", "apr mon", mon_o, 8'h05);
        load_time(23, 59, 59, 1, 30, 1, 21);
        strobe(1'b0, 1'b1);
        chk("R6", "jan dom", dom_o, 8'h31);

        // R3: binary form.
        set_fmt(1'b1, 1'b1);
        load_time(12, 34, 45, 3, 25, 11, 87);
        chk("R3", "sec", sec_o, 8'd45);
        chk("R3", "hour", hr_o, 8'd12);
        chk("R3", "yr", yr_o, 8'd87);

        // R4 and R9: 12-hour form and decode with PM flag.
        set_fmt(1'b0, 1'b0);
        load_raw(8'h00, 8'h30, 8'h91, 8'h02, 8'h10, 8'h03, 8'h22, 1'b0);
        chk("R4", "pm hour", hr_o, 8'h91);
        set_fmt(1'b0, 1'b1);
        settle();
        chk("R9", "pm decode", hr_o, 8'h23);
        set_fmt(1'b1, 1'b0);
        settle();
        chk("R4", "binary pm hour", hr_o, 8'h8B);
        set_fmt(1'b0, 1'b1);
        load_time(0, 0, 0, 0, 1, 1, 0);
        set_fmt(1'b0, 1'b0);
        settle();
        chk("R4", "midnight", hr_o, 8'h00);
        set_fmt(1'b0, 1'b1);
        load_time(12, 0, 0, 0, 1, 1, 0);
        set_fmt(1'b0, 1'b0);
        settle();
        chk("R4", "noon", hr_o, 8'h80);

        // R9: load beats tick in the same cycle.
        set_fmt(1'b0, 1'b1);
        load_raw(8'h10, 8'h20, 8'h05, 8'h01, 8'h12, 8'h07, 8'h33, 1'b1);
        chk("R9", "load over tick", sec_o, 8'h10);

        // R10: idle cycles and format changes leave state alone.
        repeat (5) settle();
        chk("R10", "idle sec", sec_o, 8'h10);
        set_fmt(1'b1, 1'b0);
        settle();
        set_fmt(1'b0, 1'b1);
        settle();
        chk("R10", "after format swap sec", sec_o, 8'h10);
        chk("R10", "after format swap min", min_o, 8'h20);

        // Soak: continuous ticks across midnight with format changes.
        load_time(23, 58, 30, 3, 28, 2, 99);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tick = 1'b1;
            if (i % 50 == 0) fbin = ~fbin;
            if (i % 70 == 0) f24 = ~f24;
        end
        @(negedge clk); tick = 1'b0;
        settle();
        finish_run();
    end

endmodule